// File: doc/BRIEF.md
# Audio Write FIFO with DMA Event Pacing

This block sits between a bus port that a DMA engine writes and a small set of audio serializers. Sample words written by the DMA are kept in a 64-word store. A level-sensitive DMA request stays high while the store has room for a full programmed burst. Stored words are handed out in groups, one word to each active serializer in ascending index order, and a group is only released once every active serializer reports ready.

A 17-bit control word sets the group size, the request threshold and the enable. Bits 7:0 give the group size, which is the number of active serializers. Bits 15:8 give the threshold in words, normally events times serializers. Bit 16 is the enable. The block's state is visible at the ports as the occupancy level and a sticky overflow flag.

The hand-off machine has three states. ST_BYPASS is used while disabled. ST_WAIT holds until a full group and ready serializers are present. ST_SEND pops one word per cycle. Its transitions are:
- ctrl_write: any state goes to ST_WAIT when the written enable is 1, or to ST_BYPASS when it is 0.
- group_ready: ST_WAIT goes to ST_SEND.
- group_done: ST_SEND goes back to ST_WAIT after the last active lane.

With the enable cleared, the store is unused. Each bus write is forwarded straight to the next serializer in rotation.

Top module: `afifo_dma_pace`

## Requirements
- R1: After reset, level is 0, overflow is 0, dma_req is 0, no ser_load bit is set, and the block is disabled.
- R2: While enabled, each accepted bus write raises level by one. Each word popped for a serializer lowers it by one. level never exceeds 64.
- R3: The effective group size n comes from control bits 7:0. A value of 0 acts as 1, and a value above the serializer count (4) acts as 4.
- R4: dma_req is high exactly when enable (bit 16) is set and free space (64 − level) is at least the effective threshold. A write that takes free space below the threshold drops dma_req on the following cycle.
- R5: Threshold bits 15:8 give the threshold in words. A value of 0, or any value above 64, falls back to n (one event group).
- R6: In ST_WAIT, once level ≥ n and ser_ready[0..n−1] are all high, the next cycle enters ST_SEND. The following n cycles pop the oldest words in order to serializers 0, 1, …, n−1. Each ser_load pulse appears in the cycle after its pop, with the word on that lane's ser_data slice (lane s at bits s*32+31:s*32).
- R7: While enabled, a write arriving when level is 64 is dropped and sets overflow. overflow stays set until the next control write.
- R8: With enable cleared, level stays 0 and dma_req stays low. Each bus write appears one cycle later as a ser_load pulse on the lane given by a rotating index 0..n−1, regardless of ser_ready.
- R9: Any control write empties the store, clears overflow and restarts the rotation at lane 0. A bus write in the same cycle is discarded.
- R10: A serializer whose index is n or above never receives a ser_load pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 17 | Control word: [7:0] group size, [15:8] threshold, [16] enable |
| wr_valid | input | 1 | Bus write of one sample word |
| wr_data | input | 32 | Sample word |
| dma_req | output | 1 | Level request for another burst |
| ser_ready | input | 4 | Per-serializer ready |
| ser_load | output | 4 | One-cycle load pulse per serializer |
| ser_data | output | 128 | Word per serializer, lane s at s*32 |
| level | output | 7 | Current occupancy |
| overflow | output | 1 | Sticky dropped-write flag |

## Verification
The bench fills the store past 64 words with every serializer stalled. A design that wraps its pointers or counter here would report a small level or overwrite the oldest samples instead of raising overflow. It programs oversize group and threshold fields and checks that the fallback to four lanes and to one group holds exactly at the 60/61-word boundary; an off-by-one compare would move the request edge by a word. It also holds one active lane not ready, and issues a control write in the same cycle as a data write. A design that ignored the idle lane would send partial groups, and one that let the data write through would leave a stale word after the flush.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

    typedef enum logic [1:0] {
        ST_BYPASS = 2'd0,
        ST_WAIT   = 2'd1,
        ST_SEND   = 2'd2
    } disp_state_e;

    typedef struct packed {
        logic       en;
        logic [7:0] thr;
        logic [7:0] grp;
    } ctrl_reg_t;

    localparam int CTRL_EN_BIT = 16;
    localparam int CTRL_W      = 17;

    function automatic ctrl_reg_t unpack_ctrl(input logic [CTRL_W-1:0] w);
        ctrl_reg_t c;
        c.en  = w[CTRL_EN_BIT];
        c.thr = w[15:8];
        c.grp = w[7:0];
        return c;
    endfunction

endpackage

// File: rtl/afifo_pace.sv
module afifo_pace
    import afifo_pkg::*;
#(
    parameter  int DEPTH = 64,
    parameter  int NSER  = 4,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int GW    = $clog2(NSER + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic [CW-1:0]     level,
    output logic              en,
    output logic [GW-1:0]     grp,
    output logic              dma_req
);

    ctrl_reg_t     cfg_q;
    logic [CW-1:0] thr_eff;
    logic [CW-1:0] free;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (ctrl_we) begin
            cfg_q <= unpack_ctrl(ctrl_wdata);
        end
    end

    // group size: zero means one lane, oversize clamps to all lanes
    always_comb begin
        if (cfg_q.grp == 8'd0) begin
            grp = GW'(1);
        end else if (int'(cfg_q.grp) > NSER) begin
            grp = GW'(NSER);
        end else begin
            grp = GW'(cfg_q.grp);
        end
    end

    // threshold: zero or beyond the depth falls back to one group
    always_comb begin
        if (cfg_q.thr == 8'd0 || int'(cfg_q.thr) > DEPTH) begin
            thr_eff = CW'(grp);
        end else begin
            thr_eff = CW'(cfg_q.thr);
        end
    end

    assign free    = CW'(DEPTH) - level;
    assign en      = cfg_q.en;
    assign dma_req = cfg_q.en && (free >= thr_eff);

endmodule

// File: rtl/afifo_store.sv
module afifo_store #(
    parameter  int DW    = 32,
    parameter  int DEPTH = 64,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push_req,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] level,
    output logic          ovf
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          ovf_q;
    logic          full, push;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full = (cnt_q == CW'(DEPTH));
    assign push = push_req && !full;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wp_q] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (push) begin
                wp_q <= step(wp_q);
            end
            if (pop) begin
                rp_q <= step(rp_q);
            end
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
            if (push_req && full) begin
                ovf_q <= 1'b1;
            end
        end
    end

    assign head  = mem[rp_q];
    assign level = cnt_q;
    assign ovf   = ovf_q;

endmodule

// File: rtl/afifo_disp.sv
module afifo_disp
    import afifo_pkg::*;
#(
    parameter  int DW    = 32,
    parameter  int DEPTH = 64,
    parameter  int NSER  = 4,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int GW    = $clog2(NSER + 1),
    localparam int IW    = $clog2(NSER)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_we,
    input  logic               ctrl_en,
    input  logic [GW-1:0]      grp,
    input  logic [CW-1:0]      level,
    input  logic [DW-1:0]      head,
    input  logic               wr_valid,
    input  logic [DW-1:0]      wr_data,
    input  logic [NSER-1:0]    ser_ready,
    output logic               pop,
    output logic [NSER-1:0]    ser_load,
    output logic [NSER*DW-1:0] ser_data
);

    disp_state_e     st_q, st_d;
    logic [IW-1:0]   idx_q;
    logic [NSER-1:0] active;
    logic [NSER-1:0] sel;
    logic [NSER-1:0] load_q;
    logic [DW-1:0]   word;
    logic            all_rdy, hand, last;

    for (genvar s = 0; s < NSER; s++) begin : g_act
        assign active[s] = (GW'(s) < grp);
    end

    assign all_rdy = &(ser_ready | ~active);
    assign last    = (GW'(idx_q) == grp - GW'(1));

    // next-state decode
    always_comb begin
        st_d = st_q;
        if (ctrl_we) begin
            st_d = ctrl_en ? ST_WAIT : ST_BYPASS;
        end else begin
            unique case (st_q)
                ST_BYPASS: st_d = ST_BYPASS;
                ST_WAIT:   if (level >= CW'(grp) && all_rdy) st_d = ST_SEND;
                ST_SEND:   if (last) st_d = ST_WAIT;
                default:   st_d = ST_BYPASS;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_BYPASS;
        end else begin
            st_q <= st_d;
        end
    end

    assign hand = !ctrl_we && ((st_q == ST_SEND) || (st_q == ST_BYPASS && wr_valid));
    assign pop  = !ctrl_we && (st_q == ST_SEND);
    assign word = (st_q == ST_SEND) ? head : wr_data;

    always_comb begin
        sel = '0;
        if (hand) begin
            sel[idx_q] = 1'b1;
        end
    end

    // output register: lane pulses and rotation index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= '0;
            idx_q  <= '0;
        end else begin
            load_q <= sel;
            if (ctrl_we || st_q == ST_WAIT) begin
                idx_q <= '0;
            end else if (hand) begin
                idx_q <= last ? '0 : idx_q + 1'b1;
            end
        end
    end

    for (genvar s = 0; s < NSER; s++) begin : g_lane
        logic [DW-1:0] lane_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (sel[s]) begin
                lane_q <= word;
            end
        end
        assign ser_data[s*DW +: DW] = lane_q;
    end

    assign ser_load = load_q;

endmodule

// File: rtl/afifo_dma_pace.sv
module afifo_dma_pace
    import afifo_pkg::*;
#(
    parameter  int DW    = 32,
    parameter  int DEPTH = 64,
    parameter  int NSER  = 4,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_we,
    input  logic [CTRL_W-1:0]  ctrl_wdata,
    input  logic               wr_valid,
    input  logic [DW-1:0]      wr_data,
    output logic               dma_req,
    input  logic [NSER-1:0]    ser_ready,
    output logic [NSER-1:0]    ser_load,
    output logic [NSER*DW-1:0] ser_data,
    output logic [CW-1:0]      level,
    output logic               overflow
);

    localparam int GW = $clog2(NSER + 1);

    logic          cfg_en;
    logic [GW-1:0] grp;
    logic          pop;
    logic [DW-1:0] head;
    logic          push_req;

    assign push_req = wr_valid && cfg_en && !ctrl_we;

    afifo_pace #(.DEPTH(DEPTH), .NSER(NSER)) u_pace (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .level      (level),
        .en         (cfg_en),
        .grp        (grp),
        .dma_req    (dma_req)
    );

    afifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (ctrl_we),
        .push_req (push_req),
        .wdata    (wr_data),
        .pop      (pop),
        .head     (head),
        .level    (level),
        .ovf      (overflow)
    );

    afifo_disp #(.DW(DW), .DEPTH(DEPTH), .NSER(NSER)) u_disp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_we   (ctrl_we),
        .ctrl_en   (ctrl_wdata[CTRL_EN_BIT]),
        .grp       (grp),
        .level     (level),
        .head      (head),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .ser_ready (ser_ready),
        .pop       (pop),
        .ser_load  (ser_load),
        .ser_data  (ser_data)
    );

endmodule

// File: rtl/afifo_chk.sv
module afifo_chk #(
    parameter  int DEPTH = 64,
    parameter  int NSER  = 4,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ctrl_we,
    input logic            wr_valid,
    input logic            cfg_en,
    input logic            dma_req,
    input logic [CW-1:0]   level,
    input logic            overflow,
    input logic [NSER-1:0] ser_load
);

    // R2
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));

    // R4
    req_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |-> !dma_req);

    // R6
    load_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ser_load));

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !ctrl_we |=> overflow);

    // R7
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en && wr_valid && !ctrl_we && level == CW'(DEPTH) |=> overflow);

    // R9
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> (level == '0) && !overflow);

endmodule

bind afifo_dma_pace afifo_chk #(.DEPTH(DEPTH), .NSER(NSER)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_we  (ctrl_we),
    .wr_valid (wr_valid),
    .cfg_en   (cfg_en),
    .dma_req  (dma_req),
    .level    (level),
    .overflow (overflow),
    .ser_load (ser_load)
);

// File: tb/test_afifo_dma_pace.sv
module test_afifo_dma_pace;

    localparam int CLK_PERIOD = 10;
    localparam int DW    = 32;
    localparam int DEPTH = 64;
    localparam int NSER  = 4;
    localparam int CW    = $clog2(DEPTH + 1);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               ctrl_we = 1'b0;
    logic [16:0]        ctrl_wdata = '0;
    logic               wr_valid = 1'b0;
    logic [DW-1:0]      wr_data = '0;
    logic [NSER-1:0]    ser_ready = '0;
    logic               dma_req;
    logic [NSER-1:0]    ser_load;
    logic [NSER*DW-1:0] ser_data;
    logic [CW-1:0]      level;
    logic               overflow;

    always #(CLK_PERIOD/2) clk = ~clk;

    afifo_dma_pace i_afifo_dma_pace (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .wr_valid(wr_valid), .wr_data(wr_data), .dma_req(dma_req),
        .ser_ready(ser_ready), .ser_load(ser_load), .ser_data(ser_data),
        .level(level), .overflow(overflow)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc_cnt = 0;
    bit cmp_on = 0;
    logic [31:0] seq = 32'hA000_0000;
    int lc [NSER];

    // behavioural reference
    logic [31:0]     mq [$];
    int              m_st, m_idx, m_wpt, m_thr, m_n, m_c0;
    bit              m_en, m_ovf, m_rdy;
    bit [NSER-1:0]   m_load;
    logic [31:0]     m_data [NSER];

    function automatic int neff(int w);
        if (w == 0) return 1;
        if (w > NSER) return NSER;
        return w;
    endfunction

    function automatic int theff(int t, int w);
        if (t == 0 || t > DEPTH) return neff(w);
        return t;
    endfunction

    function automatic bit exp_req();
        return m_en && ((DEPTH - mq.size()) >= theff(m_thr, m_wpt));
    endfunction

    function automatic string lane_tag(int s);
        if (s >= neff(m_wpt)) return "R10 idle lane";
        if (m_en) return "R6 group lane";
        return "R8 bypass lane";
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        m_load = '0;
        if (!rst_n) begin
            mq.delete();
            m_st = 0; m_idx = 0; m_en = 0; m_wpt = 0; m_thr = 0; m_ovf = 0;
        end else if (ctrl_we) begin
            mq.delete();
            m_ovf = 0;
            m_en  = ctrl_wdata[16];
            m_thr = int'(ctrl_wdata[15:8]);
            m_wpt = int'(ctrl_wdata[7:0]);
            m_st  = m_en ? 1 : 0;
            m_idx = 0;
        end else begin
            m_n  = neff(m_wpt);
            m_c0 = mq.size();
            if (m_st == 0) begin
                if (wr_valid) begin
                    m_load[m_idx] = 1'b1;
                    m_data[m_idx] = wr_data;
                    m_idx = (m_idx + 1 == m_n) ? 0 : m_idx + 1;
                end
            end else if (m_st == 1) begin
                m_rdy = 1;
                for (int s = 0; s < m_n; s++) if (!ser_ready[s]) m_rdy = 0;
                if (m_c0 >= m_n && m_rdy) begin
                    m_st = 2;
                    m_idx = 0;
                end
            end else begin
                m_load[m_idx] = 1'b1;
                m_data[m_idx] = mq.pop_front();
                if (m_idx == m_n - 1) begin
                    m_st = 1;
                    m_idx = 0;
                end else begin
                    m_idx++;
                end
            end
            if (m_en && wr_valid) begin
                if (m_c0 == DEPTH) m_ovf = 1;
                else mq.push_back(wr_data);
            end
        end
    end

    // every-cycle comparison against the reference
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R2 level", 64'(level), 64'(mq.size()));
            chk("R4 dma_req", 64'(dma_req), 64'(exp_req()));
            chk("R7 overflow", 64'(overflow), 64'(m_ovf));
            for (int s = 0; s < NSER; s++) begin
                chk(lane_tag(s), 64'(ser_load[s]), 64'(m_load[s]));
                if (m_load[s]) chk(lane_tag(s), 64'(ser_data[s*DW +: DW]), 64'(m_data[s]));
                if (ser_load[s]) lc[s]++;
            end
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt == 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=done", cyc_cnt);
            summary();
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input logic [16:0] w);
        ctrl_wdata = w;
        ctrl_we = 1'b1;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic put(input int n);
        repeat (n) begin
            wr_valid = 1'b1;
            wr_data = seq;
            seq++;
            @(negedge clk);
        end
        wr_valid = 1'b0;
    endtask

    task automatic clr_lc();
        for (int s = 0; s < NSER; s++) lc[s] = 0;
    endtask

    logic [15:0] lfsr = 16'hACE1;

    initial begin
        clr_lc();
        cyc(4);
        rst_n = 1'b1;
        cmp_on = 1;
        cyc(1); #1;
        // R1 reset state
        chk("R1 level", 64'(level), 0);
        chk("R1 dma_req", 64'(dma_req), 0);
        chk("R1 ser_load", 64'(ser_load), 0);
        chk("R1 overflow", 64'(overflow), 0);

        // two lanes, threshold 8
        ser_ready = 4'hF;
        cfg(17'h10802); #1;
        chk("R4 request after enable", 64'(dma_req), 1);
        clr_lc();
        put(10);
        cyc(20); #1;
        chk("R6 drained", 64'(level), 0);
        chk("R6 lane0 loads", 64'(lc[0]), 5);
        chk("R6 lane1 loads", 64'(lc[1]), 5);
        chk("R10 lane2 loads", 64'(lc[2]), 0);
        chk("R10 lane3 loads", 64'(lc[3]), 0);

        // one active lane not ready holds the group
        ser_ready = 4'b1101;
        put(6);
        cyc(10); #1;
        chk("R6 held by ready", 64'(level), 6);
        ser_ready = 4'hF;
        cyc(15); #1;
        chk("R6 released", 64'(level), 0);

        // overfill with all lanes stalled
        ser_ready = 4'h0;
        put(70);
        cyc(3); #1;
        chk("R7 full level", 64'(level), 64);
        chk("R7 overflow set", 64'(overflow), 1);
        chk("R4 no room", 64'(dma_req), 0);

        // oversize group, zero threshold
        cfg(17'h10009); #1;
        chk("R9 flushed", 64'(level), 0);
        chk("R9 overflow cleared", 64'(overflow), 0);
        ser_ready = 4'hF;
        clr_lc();
        put(12);
        cyc(30); #1;
        for (int s = 0; s < NSER; s++) chk("R3 clamp to four lanes", 64'(lc[s]), 3);

        // threshold 200 falls back to the group size 4
        cfg(17'h1C804);
        ser_ready = 4'h0;
        put(60); #1;
        chk("R5 free 4 requests", 64'(dma_req), 1);
        put(1); #1;
        chk("R5 free 3 silent", 64'(dma_req), 0);
        chk("R5 level", 64'(level), 61);

        // disabled: bypass over three lanes, ready ignored
        cfg(17'h00003);
        clr_lc();
        put(7);
        cyc(2); #1;
        chk("R8 lane0", 64'(lc[0]), 3);
        chk("R8 lane1", 64'(lc[1]), 2);
        chk("R8 lane2", 64'(lc[2]), 2);
        chk("R10 lane3", 64'(lc[3]), 0);
        chk("R8 level", 64'(level), 0);
        chk("R8 dma_req", 64'(dma_req), 0);

        // control write and data write together
        ctrl_wdata = 17'h10101;
        ctrl_we = 1'b1;
        wr_valid = 1'b1;
        wr_data = 32'hDEAD_BEEF;
        @(negedge clk);
        ctrl_we = 1'b0;
        wr_valid = 1'b0;
        #1;
        chk("R9 same-cycle write dropped", 64'(level), 0);
        chk("R9 no forward", 64'(ser_load), 0);

        // pseudo-random traffic, three lanes, threshold 12
        cfg(17'h10C03);
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            wr_valid = lfsr[0];
            wr_data = seq;
            seq++;
            ser_ready = lfsr[4:1] | (lfsr[7] ? 4'hF : 4'h0);
            @(negedge clk);
        end
        wr_valid = 1'b0;
        ser_ready = 4'hF;
        cyc(20);
        summary();
    end

endmodule